// File: doc/BRIEF.md
# Branch Decision Unit

This combinational unit sits in the execute path of a 16-bit register machine. From the instruction word just fetched, the program counter (already advanced past that word), the four condition flags and the contents of one general register, it decides in the same cycle whether control flow changes and, if so, where it goes.

It recognises two kinds of instruction:

- **Flag-tested branches.** These carry a condition selector in the high byte and a signed word displacement in the low byte.
- **The count-down loop instruction.** This decrements a named register, reports the new value with a write-back strobe, and jumps backwards while the new value is nonzero.

Every other word is flagged as not handled, and the program counter passes through unchanged. The unit has no outputs for the flags, so it cannot alter them.

Top module: `br_decide_unit`

## Requirements
- R1: A word is a branch when bits 14:11 are zero and the condition code {bit 15, bits 10:8} is nonzero; this covers high bytes 0x01–0x07 and 0x80–0x87.
- R2: For a taken branch, next_pc_o equals pc_i plus twice the sign-extended low byte, modulo 2^16. For a branch not taken, next_pc_o equals pc_i.
- R3: Flags are C at bit 0, V at bit 1, Z at bit 2 and N at bit 3. Code 1 always branches, code 2 branches when Z=0, and code 3 branches when Z=1.
- R4: Code 4 branches when N^V=0. Code 5 branches when N^V=1. Code 6 branches when Z|(N^V)=0. Code 7 branches when Z|(N^V)=1.
- R5: Code 8 branches when N=0 and code 9 when N=1. Code 12 branches when V=0 and code 13 when V=1. Code 14 branches when C=0 and code 15 when C=1.
- R6: Code 10 branches when C=0 and Z=0. Code 11 branches when C|Z=1.
- R7: A word whose bits 15:9 are 0111111 is the loop instruction. For it, reg_sel_o equals bits 8:6, wb_en_o is 1, and wb_val_o equals reg_val_i minus 1, modulo 2^16.
- R8: For the loop instruction, taken_o is 1 exactly when wb_val_o is nonzero. When taken, next_pc_o equals pc_i minus twice bits 5:0. When not taken, next_pc_o equals pc_i.
- R9: Any other word sets unknown_o to 1, taken_o to 0 and wb_en_o to 0, and next_pc_o equals pc_i. For recognised words, unknown_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| instr_i | input | 16 | Instruction word under execution |
| pc_i | input | DATA_W | Program counter, already incremented |
| flags_i | input | 4 | Condition flags {N,Z,V,C} |
| reg_val_i | input | DATA_W | Value of the register named by reg_sel_o |
| reg_sel_o | output | 3 | Register field of the instruction |
| taken_o | output | 1 | Control transfer happens |
| next_pc_o | output | DATA_W | Program counter to use next |
| wb_en_o | output | 1 | Write wb_val_o to the register reg_sel_o |
| wb_val_o | output | DATA_W | Decremented register value |
| unknown_o | output | 1 | Instruction not handled by this unit |

## Verification
The loop instruction raises its write-back and makes its branch decision in the same evaluation, and the decision depends on the value being written back. The bench drives register values 1, 2, 0 and 0x8000 together with several count fields. It then judges the strobe, the decremented value, the taken bit and the backward target against each other and against independently computed values. At a count of 1, the register is written but no branch is taken. At a count of 0, the value wraps to all ones and the branch is taken.

// File: rtl/br_pkg.sv
package br_pkg;

    localparam int INSTR_W = 16;

    typedef enum logic [3:0] {
        CND_NONE   = 4'h0,
        CND_ALWAYS = 4'h1,
        CND_NE     = 4'h2,
        CND_EQ     = 4'h3,
        CND_GE     = 4'h4,
        CND_LT     = 4'h5,
        CND_GT     = 4'h6,
        CND_LE     = 4'h7,
        CND_PL     = 4'h8,
        CND_MI     = 4'h9,
        CND_HI     = 4'hA,
        CND_LOS    = 4'hB,
        CND_VC     = 4'hC,
        CND_VS     = 4'hD,
        CND_CC     = 4'hE,
        CND_CS     = 4'hF
    } cond_e;

    typedef struct packed {
        logic       is_branch;
        logic       is_loop;
        cond_e      cond;
        logic [7:0] disp;
        logic [5:0] count;
        logic [2:0] reg_idx;
    } dec_t;

endpackage

// File: rtl/br_decode.sv
module br_decode
    import br_pkg::*;
(
    input  logic [INSTR_W-1:0] instr_i,
    output dec_t               dec_o
);
    logic [3:0] code;

    always_comb begin
        code = {instr_i[15], instr_i[10:8]};
        dec_o = '0;
        dec_o.disp    = instr_i[7:0];
        dec_o.count   = instr_i[5:0];
        dec_o.reg_idx = instr_i[8:6];
        // R1: branch class
        if (instr_i[14:11] == 4'b0000 && code != 4'h0) begin
            dec_o.is_branch = 1'b1;
            dec_o.cond      = cond_e'(code);
        end
        // R7: loop class
        if (instr_i[15:9] == 7'b0111111) begin
            dec_o.is_loop = 1'b1;
        end
    end
endmodule

// File: rtl/br_cond_eval.sv
module br_cond_eval
    import br_pkg::*;
(
    input  cond_e      cond_i,
    input  logic [3:0] flags_i,
    output logic       pass_o
);
    logic c, v, z, n, sx;

    always_comb begin
        c  = flags_i[0];
        v  = flags_i[1];
        z  = flags_i[2];
        n  = flags_i[3];
        sx = n ^ v;
        unique case (cond_i)
            CND_ALWAYS: pass_o = 1'b1;
            CND_NE:     pass_o = ~z;
            CND_EQ:     pass_o = z;
            CND_GE:     pass_o = ~sx;
            CND_LT:     pass_o = sx;
            CND_GT:     pass_o = ~(z | sx);
            CND_LE:     pass_o = z | sx;
            CND_PL:     pass_o = ~n;
            CND_MI:     pass_o = n;
            CND_HI:     pass_o = ~(c | z);
            CND_LOS:    pass_o = c | z;
            CND_VC:     pass_o = ~v;
            CND_VS:     pass_o = v;
            CND_CC:     pass_o = ~c;
            CND_CS:     pass_o = c;
            default:    pass_o = 1'b0;
        endcase
    end
endmodule

// File: rtl/br_target.sv
module br_target #(
    parameter int DATA_W = 16
) (
    input  logic [DATA_W-1:0] pc_i,
    input  logic [7:0]        disp_i,
    input  logic [5:0]        count_i,
    output logic [DATA_W-1:0] fwd_pc_o,
    output logic [DATA_W-1:0] back_pc_o
);
    localparam int SEXT_W = DATA_W - 9;
    localparam int ZEXT_W = DATA_W - 7;

    logic [DATA_W-1:0] disp_bytes;
    logic [DATA_W-1:0] count_bytes;

    always_comb begin
        disp_bytes  = {{SEXT_W{disp_i[7]}}, disp_i, 1'b0};
        count_bytes = {{ZEXT_W{1'b0}}, count_i, 1'b0};
        fwd_pc_o    = pc_i + disp_bytes;
        back_pc_o   = pc_i - count_bytes;
    end
endmodule

// File: rtl/br_decide_unit.sv
module br_decide_unit
    import br_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic [INSTR_W-1:0] instr_i,
    input  logic [DATA_W-1:0]  pc_i,
    input  logic [3:0]         flags_i,
    input  logic [DATA_W-1:0]  reg_val_i,
    output logic [2:0]         reg_sel_o,
    output logic               taken_o,
    output logic [DATA_W-1:0]  next_pc_o,
    output logic               wb_en_o,
    output logic [DATA_W-1:0]  wb_val_o,
    output logic               unknown_o
);
    localparam logic [DATA_W-1:0] ONE = {{(DATA_W-1){1'b0}}, 1'b1};

    dec_t              dec;
    logic              cond_pass;
    logic [DATA_W-1:0] fwd_pc;
    logic [DATA_W-1:0] back_pc;
    logic [DATA_W-1:0] dec_val;

    br_decode u_decode (
        .instr_i (instr_i),
        .dec_o   (dec)
    );

    br_cond_eval u_cond (
        .cond_i  (dec.cond),
        .flags_i (flags_i),
        .pass_o  (cond_pass)
    );

    br_target #(.DATA_W(DATA_W)) u_target (
        .pc_i      (pc_i),
        .disp_i    (dec.disp),
        .count_i   (dec.count),
        .fwd_pc_o  (fwd_pc),
        .back_pc_o (back_pc)
    );

    always_comb begin
        dec_val   = reg_val_i - ONE;
        reg_sel_o = dec.reg_idx;
        unknown_o = ~(dec.is_branch | dec.is_loop);
        wb_en_o   = dec.is_loop;
        wb_val_o  = dec.is_loop ? dec_val : '0;
        taken_o   = 1'b0;
        next_pc_o = pc_i;
        if (dec.is_branch && cond_pass) begin
            taken_o   = 1'b1;
            next_pc_o = fwd_pc;
        end else if (dec.is_loop && dec_val != '0) begin
            taken_o   = 1'b1;
            next_pc_o = back_pc;
        end
    end

    // Checks across the decoder, evaluator and datapath
    always_comb begin
        a_r1_class_exclusive: assert ($onehot({dec.is_branch, dec.is_loop, unknown_o}))
            else $error("R1 class overlap");
        a_r3_always_taken: assert (!(dec.is_branch && dec.cond == CND_ALWAYS) || taken_o)
            else $error("R3 unconditional branch not taken");
        a_r7_wb_only_loop: assert (wb_en_o == dec.is_loop)
            else $error("R7 write-back strobe mismatch");
        a_r8_loop_nonzero: assert (!dec.is_loop || (taken_o == (wb_val_o != '0)))
            else $error("R8 loop decision mismatch");
        a_r9_unknown_quiet: assert (!unknown_o || (!taken_o && !wb_en_o && next_pc_o == pc_i))
            else $error("R9 unhandled word had effect");
        a_r2_not_taken_hold: assert (taken_o || next_pc_o == pc_i)
            else $error("R2 pc moved without a taken branch");
    end
endmodule

// File: tb/br_decide_unit_tb_top.sv
module br_decide_unit_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 20000;

    logic        clk = 1'b0;
    logic [15:0] instr;
    logic [15:0] pc;
    logic [3:0]  flags;
    logic [15:0] rval;
    logic [2:0]  reg_sel;
    logic        taken;
    logic [15:0] next_pc;
    logic        wb_en;
    logic [15:0] wb_val;
    logic        unknown;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    br_decide_unit #(.DATA_W(16)) dut_i (
        .instr_i   (instr),
        .pc_i      (pc),
        .flags_i   (flags),
        .reg_val_i (rval),
        .reg_sel_o (reg_sel),
        .taken_o   (taken),
        .next_pc_o (next_pc),
        .wb_en_o   (wb_en),
        .wb_val_o  (wb_val),
        .unknown_o (unknown)
    );

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s got=%0h exp=%0h", tag, got, exp);
        end
    endtask

    task automatic apply(input logic [15:0] i, input logic [15:0] p,
                         input logic [3:0] f, input logic [15:0] r);
        @(negedge clk);
        instr = i; pc = p; flags = f; rval = r;
        #1;
    endtask

    // Model of the condition table, written from the requirement text
    function automatic bit want(input int code, input logic [3:0] f);
        bit cf = f[0], vf = f[1], zf = f[2], nf = f[3];
        case (code)
            1:  return 1;
            2:  return !zf;
            3:  return zf;
            4:  return nf == vf;
            5:  return nf != vf;
            6:  return !zf && (nf == vf);
            7:  return zf || (nf != vf);
            8:  return !nf;
            9:  return nf;
            10: return !cf && !zf;
            11: return cf || zf;
            12: return !vf;
            13: return vf;
            14: return !cf;
            15: return cf;
            default: return 0;
        endcase
    endfunction

    function automatic logic [15:0] branch_word(input int code, input logic [7:0] off);
        logic [15:0] w;
        w = 16'h0000;
        w[15]   = code[3];
        w[10:8] = code[2:0];
        w[7:0]  = off;
        return w;
    endfunction

    // Idle / quiet word as the starting state
    task automatic t_idle();
        apply(16'h0000, 16'h1000, 4'h0, 16'h0000);
        chk("R9 idle taken", taken, 0);
        chk("R9 idle unknown", unknown, 1);
        chk("R9 idle next", next_pc, 16'h1000);
        chk("R9 idle wb", wb_en, 0);
    endtask

    // Every condition against every flag pattern
    task automatic t_conditions();
        for (int code = 1; code < 16; code++) begin
            for (int f = 0; f < 16; f++) begin
                bit w;
                string tg;
                w = want(code, 4'(f));
                apply(branch_word(code, 8'h05), 16'h2000, 4'(f), 16'h0);
                if (code <= 3)       tg = "R3";
                else if (code <= 7)  tg = "R4";
                else if (code == 10 || code == 11) tg = "R6";
                else                 tg = "R5";
                chk($sformatf("%s code=%0d flags=%0h taken", tg, code, f), taken, w);
                chk($sformatf("R2 code=%0d flags=%0h next", code, f), next_pc,
                    w ? 16'h200A : 16'h2000);
                chk($sformatf("R1 code=%0d unknown", code), unknown, 0);
                chk($sformatf("R1 code=%0d wb", code), wb_en, 0);
            end
        end
    endtask

    // Offset extremes and modular wrap
    task automatic t_offsets();
        apply(branch_word(1, 8'h7F), 16'h0100, 4'h0, 16'h0);
        chk("R2 max forward", next_pc, 16'h01FE);
        apply(branch_word(1, 8'h80), 16'h0100, 4'h0, 16'h0);
        chk("R2 max backward", next_pc, 16'h0000);
        apply(branch_word(1, 8'hFF), 16'h0100, 4'h0, 16'h0);
        chk("R2 minus one word", next_pc, 16'h00FE);
        apply(branch_word(1, 8'h10), 16'hFFF0, 4'h0, 16'h0);
        chk("R2 wrap high", next_pc, 16'h0010);
        apply(branch_word(1, 8'h80), 16'h0020, 4'h0, 16'h0);
        chk("R2 wrap low", next_pc, 16'hFF20);
    endtask

    // Loop instruction: write-back and decision together
    task automatic t_loop();
        logic [15:0] w;
        w = 16'h7E00 | (16'd5 << 6) | 16'd3;   // reg 5, count 3
        apply(w, 16'h0400, 4'hF, 16'h0002);
        chk("R7 sel", reg_sel, 5);
        chk("R7 wb_en", wb_en, 1);
        chk("R7 wb_val", wb_val, 16'h0001);
        chk("R8 taken", taken, 1);
        chk("R8 target", next_pc, 16'h03FA);
        chk("R7 unknown", unknown, 0);
        apply(w, 16'h0400, 4'h0, 16'h0001);
        chk("R7 wb at one", wb_en, 1);
        chk("R7 val at one", wb_val, 16'h0000);
        chk("R8 exit taken", taken, 0);
        chk("R8 exit next", next_pc, 16'h0400);
        w = 16'h7E00 | (16'd7 << 6) | 16'd63;
        apply(w, 16'h0010, 4'h0, 16'h0000);
        chk("R7 sel seven", reg_sel, 7);
        chk("R7 wrap val", wb_val, 16'hFFFF);
        chk("R8 wrap taken", taken, 1);
        chk("R8 wrap target", next_pc, 16'hFF92);
        w = 16'h7E00;
        apply(w, 16'h0050, 4'h0, 16'h8000);
        chk("R7 sel zero", reg_sel, 0);
        chk("R7 val 8000", wb_val, 16'h7FFF);
        chk("R8 zero count", next_pc, 16'h0050);
        chk("R8 zero count taken", taken, 1);
    endtask

    // Words that look close to handled ones
    task automatic t_unknown();
        logic [15:0] words [7] = '{16'h00FF, 16'h0840, 16'h7C00, 16'h8800,
                                   16'hFFFF, 16'h1234, 16'h80FF};
        logic [15:0] exp_u [7] = '{1, 1, 1, 1, 1, 1, 0};
        for (int k = 0; k < 7; k++) begin
            apply(words[k], 16'h3000, 4'hF, 16'h0005);
            chk($sformatf("R9 word %0h unknown", words[k]), unknown, exp_u[k][0]);
            if (exp_u[k][0]) begin
                chk($sformatf("R9 word %0h taken", words[k]), taken, 0);
                chk($sformatf("R9 word %0h next", words[k]), next_pc, 16'h3000);
                chk($sformatf("R9 word %0h wb", words[k]), wb_en, 0);
            end
        end
    endtask

    initial begin
        instr = 0; pc = 0; flags = 0; rval = 0;
        t_idle();
        t_conditions();
        t_offsets();
        t_loop();
        t_unknown();
        if (!done) begin
            done = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        for (int c = 0; c < WATCHDOG; c++) @(posedge clk);
        if (!done) begin
            done = 1;
            total++;
            bad++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule